// File: doc/BRIEF.md
# Triangle Spread-Spectrum Offset Generator

This block produces a signed frequency-offset word that a PWM clock generator adds to its nominal switching frequency. The word walks up and down in a triangle between a positive and a negative deviation limit, one step per pulse of a modulation-rate strobe. Spreading the switching energy this way lowers the peak of the emitted spectrum.

At each end of the triangle the sweep can pause for a dwell time. The dwell length is a number of strobe pulses, drawn afresh at each turning point from a small pseudo-random source and scaled into a window set by a lower and an upper bound. When the window is empty or the bounds are zero, the sweep turns at once. The output unit is 0.5 % of the nominal frequency.

Top module: `ssm_tri_mod`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `freq_offset` is 0, `dwell_hold` is 0, the sweep direction is upward and the dwell random state is 4'b0001.
- R2: The triangle runs only when `ss_mode[0]` is 1 (mode values 1 and 3). With `ss_mode` 0 or 2, at the next edge `freq_offset` becomes 0, `dwell_hold` becomes 0 and the direction becomes upward; the dwell random state is kept.
- R3: `tri_range_sel` picks the limit R in 0.5 % units: 0 gives 13, 1 gives 27, 2 gives 10, 3 gives 20. The sweep turns when it reaches +R or -R.
- R4: Without a strobe on `fss_tick` the output does not change. On a strobe with no dwell running, the output moves by exactly one unit in the current direction.
- R5: From the centre the first move is upward. Arriving at +R sets the direction downward; arriving at -R sets it upward.
- R6: If a range change leaves the output beyond the new limit, each strobe moves it one unit back toward zero until it is within range. The direction afterwards points toward zero.
- R7: Dwell is active only when `dwell_lo` is non-zero and `dwell_hi` is greater than `dwell_lo`. In every other setting (either bound zero, equal bounds, upper below lower) an extreme value lasts for a single strobe.
- R8: With dwell active, on arrival at an extreme the block loads a hold length L = lo + ((s * (hi - lo + 1)) >> 4), where s is the 4-bit random state. The extreme value then stays for L further strobes, and `dwell_hold` is high while strobes remain to be held.
- R9: The random state advances only when a hold length is loaded, and it uses its pre-advance value for that load. The next state is {s[2:0], s[3]^s[2]}.
- R10: The dwell bounds are sampled only at the load. Changing them while a hold is running does not alter that hold.
- R11: `freq_offset` and `dwell_hold` are registers. They take their new value at the clock edge where the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fss_tick | input | 1 | Modulation-rate strobe, one clock wide |
| ss_mode | input | 2 | Spread mode; bit 0 enables the triangle |
| tri_range_sel | input | 2 | Deviation limit select |
| dwell_lo | input | 4 | Lower dwell bound in strobes |
| dwell_hi | input | 4 | Upper dwell bound in strobes |
| freq_offset | output | OFS_W | Signed offset in 0.5 % units |
| dwell_hold | output | 1 | High while a dwell is in progress |

## Verification
The direction bit, the hold counter and the random state are all hidden. A fault in any of them shows up at the ports within one sweep, at the latest at the next turning point. A flipped direction gives a wrong step on the next strobe. A wrong hold counter gives a plateau of the wrong length. A wrong random-state update does not show at the first dwell, but it shows as a wrong plateau length at the second or third dwell. The bench therefore compares both outputs on every clock against a model, and it times plateaus over several consecutive turns.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  typedef enum logic [1:0] {
    SSM_OFF  = 2'd0,
    SSM_TRI  = 2'd1,
    SSM_RND  = 2'd2,
    SSM_BOTH = 2'd3
  } ssm_mode_e;

  localparam int RANGE_MAX = 27;

  function automatic int range_units(input logic [1:0] sel);
    case (sel)
      2'd0:    range_units = 13;
      2'd1:    range_units = 27;
      2'd2:    range_units = 10;
      default: range_units = 20;
    endcase
  endfunction

  function automatic logic tri_enabled(input logic [1:0] mode);
    tri_enabled = (mode == SSM_TRI) || (mode == SSM_BOTH);
  endfunction

endpackage

// File: rtl/ssm_lfsr.sv
module ssm_lfsr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] q
);
  logic fb;

  generate
    if (W == 4) begin : g_w4
      assign fb = q[3] ^ q[2];
    end else if (W == 5) begin : g_w5
      assign fb = q[4] ^ q[2];
    end else begin : g_wn
      assign fb = q[W-1] ^ q[W-2];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q <= W'(1);
    else if (adv) q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/ssm_dwell.sv
module ssm_dwell #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic          arrive,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] rnd,
  output logic          rnd_adv,
  output logic          holding
);
  localparam int PW = 2 * DW + 1;

  logic [DW-1:0] cnt_q;
  logic          active;
  logic [DW:0]   span;
  logic [PW-1:0] prod;
  logic [DW-1:0] len;
  logic          load;

  always_comb begin
    active  = (lo != '0) && (hi > lo);
    span    = {1'b0, hi} - {1'b0, lo} + (DW+1)'(1);
    prod    = PW'(rnd) * PW'(span);
    len     = lo + prod[2*DW-1:DW];
    load    = tick && (cnt_q == '0) && arrive && active;
    rnd_adv = load;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick) begin
      if (cnt_q != '0) cnt_q <= cnt_q - DW'(1);
      else if (load)   cnt_q <= len;
    end
  end

  assign holding = (cnt_q != '0);
endmodule

// File: rtl/ssm_tri_core.sv
module ssm_tri_core #(
  parameter int OW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 step,
  input  logic signed [OW-1:0] lim,
  output logic signed [OW-1:0] ofs,
  output logic                 arrive
);
  localparam logic signed [OW-1:0] ONE = OW'(1);

  logic signed [OW-1:0] ofs_q, nxt, neg_lim;
  logic                 up_q, go_up, up_nxt;

  always_comb begin
    neg_lim = -lim;
    go_up   = up_q ? (ofs_q < lim) : (ofs_q <= neg_lim);
    nxt     = go_up ? (ofs_q + ONE) : (ofs_q - ONE);
    arrive  = go_up ? (nxt == lim) : (nxt == neg_lim);
    up_nxt  = go_up ? !(nxt >= lim) : (nxt <= neg_lim);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ofs_q <= '0;
      up_q  <= 1'b1;
    end else if (step) begin
      ofs_q <= nxt;
      up_q  <= up_nxt;
    end
  end

  assign ofs = ofs_q;
endmodule

// File: rtl/ssm_tri_mod.sv
module ssm_tri_mod #(
  parameter int OFS_W   = 8,
  parameter int DWELL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fss_tick,
  input  logic [1:0]              ss_mode,
  input  logic [1:0]              tri_range_sel,
  input  logic [DWELL_W-1:0]      dwell_lo,
  input  logic [DWELL_W-1:0]      dwell_hi,
  output logic signed [OFS_W-1:0] freq_offset,
  output logic                    dwell_hold
);
  logic                    en, clr, step, arrive, rnd_adv, holding;
  logic signed [OFS_W-1:0] lim;
  logic [DWELL_W-1:0]      rnd;

  assign en   = ssm_pkg::tri_enabled(ss_mode);
  assign clr  = !en;
  assign lim  = OFS_W'(ssm_pkg::range_units(tri_range_sel));
  assign step = en && fss_tick && !holding;

  ssm_tri_core #(.OW(OFS_W)) u_core (
    .clk(clk), .rst(rst), .clr(clr), .step(step), .lim(lim),
    .ofs(freq_offset), .arrive(arrive)
  );

  ssm_dwell #(.DW(DWELL_W)) u_dwell (
    .clk(clk), .rst(rst), .clr(clr), .tick(en && fss_tick),
    .arrive(arrive), .lo(dwell_lo), .hi(dwell_hi), .rnd(rnd),
    .rnd_adv(rnd_adv), .holding(holding)
  );

  ssm_lfsr #(.W(DWELL_W)) u_lfsr (
    .clk(clk), .rst(rst), .adv(rnd_adv), .q(rnd)
  );

  assign dwell_hold = holding;
endmodule

// File: rtl/ssm_tri_mod_chk.sv
module ssm_tri_mod_chk #(
  parameter int OFS_W   = 8,
  parameter int DWELL_W = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    fss_tick,
  input logic [1:0]              ss_mode,
  input logic [1:0]              tri_range_sel,
  input logic [DWELL_W-1:0]      dwell_lo,
  input logic [DWELL_W-1:0]      dwell_hi,
  input logic signed [OFS_W-1:0] freq_offset,
  input logic                    dwell_hold
);
  // R2
  mode_off_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !ss_mode[0] |=> (freq_offset == '0 && !dwell_hold));

  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (ss_mode[0] && !fss_tick) |=> $stable(freq_offset));

  // R4
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ss_mode[0] && fss_tick && !dwell_hold) |=>
      ((int'(freq_offset) - int'($past(freq_offset)) == 1) ||
       (int'(freq_offset) - int'($past(freq_offset)) == -1)));

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (ss_mode[0] && fss_tick && dwell_hold) |=> $stable(freq_offset));

  // R7
  hold_needs_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dwell_hold) |-> $past(dwell_lo != '0 && dwell_hi > dwell_lo));

  // R3
  range_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(freq_offset) <= ssm_pkg::RANGE_MAX) &&
    (int'(freq_offset) >= -ssm_pkg::RANGE_MAX));
endmodule

bind ssm_tri_mod ssm_tri_mod_chk #(.OFS_W(OFS_W), .DWELL_W(DWELL_W)) chk_i (.*);

// File: tb/ssm_tri_mod_test.sv
module ssm_tri_mod_test;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              fss_tick = 1'b0;
  logic [1:0]        ss_mode = 2'd0;
  logic [1:0]        tri_range_sel = 2'd0;
  logic [3:0]        dwell_lo = 4'd0;
  logic [3:0]        dwell_hi = 4'd0;
  logic signed [7:0] freq_offset;
  logic              dwell_hold;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_tag = "R1";

  int       m_off, m_hold;
  bit       m_up;
  bit [3:0] m_rnd;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssm_tri_mod uut (
    .clk(clk), .rst(rst), .fss_tick(fss_tick), .ss_mode(ss_mode),
    .tri_range_sel(tri_range_sel), .dwell_lo(dwell_lo), .dwell_hi(dwell_hi),
    .freq_offset(freq_offset), .dwell_hold(dwell_hold)
  );

  function automatic int lim_of(input bit [1:0] s);
    case (s)
      2'd0: return 13;
      2'd1: return 27;
      2'd2: return 10;
      default: return 20;
    endcase
  endfunction

  function automatic bit [3:0] rnd_next(input bit [3:0] s);
    return {s[2:0], s[3] ^ s[2]};
  endfunction

  task automatic model_reset();
    m_off = 0; m_hold = 0; m_up = 1; m_rnd = 4'd1;
  endtask

  task automatic model_step();
    int r, nv;
    bit gu;
    if (rst) begin model_reset(); return; end
    if (!ss_mode[0]) begin m_off = 0; m_hold = 0; m_up = 1; return; end
    if (!fss_tick) return;
    if (m_hold > 0) begin m_hold--; return; end
    r  = lim_of(tri_range_sel);
    gu = m_up ? (m_off < r) : (m_off <= -r);
    nv = gu ? m_off + 1 : m_off - 1;
    m_up = gu;
    if (gu && nv >= r) m_up = 0;
    if (!gu && nv <= -r) m_up = 1;
    if (((gu && nv == r) || (!gu && nv == -r)) &&
        dwell_lo != 0 && dwell_hi > dwell_lo) begin
      m_hold = int'(dwell_lo) +
               ((int'(m_rnd) * (int'(dwell_hi) - int'(dwell_lo) + 1)) >> 4);
      m_rnd  = rnd_next(m_rnd);
    end
    m_off = nv;
  endtask

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // one clock: inputs already set, sample edge, compare 1 time unit later
  task automatic cyc(input bit t);
    fss_tick = t;
    @(posedge clk);
    model_step();
    #1;
    chk(cur_tag, int'(freq_offset), m_off, "offset");
    chk(cur_tag, int'(dwell_hold), (m_hold > 0) ? 1 : 0, "hold flag");
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(0);
    cyc(0);
    rst = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1);
  endtask

  // count strobes until the output leaves value v
  task automatic plateau(input int v, output int n);
    n = 0;
    for (int i = 0; i < 40 && int'(freq_offset) == v; i++) begin
      cyc(1);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    model_reset();
    cur_tag = "R1";
    do_reset();
    chk("R1", int'(freq_offset), 0, "reset offset");
    chk("R1", int'(dwell_hold), 0, "reset hold");

    // R3 / R5 basic sweep, limit 10, no dwell
    cur_tag = "R5";
    ss_mode = 2'd1; tri_range_sel = 2'd2;
    ticks(10);
    chk("R3", int'(freq_offset), 10, "top at sel 2");
    cyc(1);
    chk("R5", int'(freq_offset), 9, "turn down");
    ticks(19);
    chk("R5", int'(freq_offset), -10, "bottom");
    cyc(1);
    chk("R5", int'(freq_offset), -9, "turn up");

    // R4 / R11 no strobe: no change
    cur_tag = "R11";
    n = int'(freq_offset);
    cyc(0); cyc(0); cyc(0);
    chk("R4", int'(freq_offset), n, "idle stable");

    // R2 mode 2 clears; mode 1 restarts upward
    cur_tag = "R2";
    ss_mode = 2'd2; cyc(1);
    chk("R2", int'(freq_offset), 0, "mode 2 zero");
    ss_mode = 2'd3; cyc(1);
    chk("R2", int'(freq_offset), 1, "mode 3 up from centre");

    // R7 equal bounds and inverted bounds: no dwell
    cur_tag = "R7";
    dwell_lo = 4'd5; dwell_hi = 4'd5;
    ticks(9);
    chk("R7", int'(freq_offset), 10, "top eq bounds");
    chk("R7", int'(dwell_hold), 0, "no hold eq bounds");
    dwell_lo = 4'd6; dwell_hi = 4'd2;
    ticks(20);
    chk("R7", int'(freq_offset), -10, "bottom inverted bounds");
    chk("R7", int'(dwell_hold), 0, "no hold inverted");
    dwell_lo = 4'd0; dwell_hi = 4'd9;
    ticks(20);
    chk("R7", int'(dwell_hold), 0, "no hold lo zero");

    // R8 / R9 / R10 dwell lengths 2,3,4 from states 1,2,4
    cur_tag = "R8";
    ss_mode = 2'd1; tri_range_sel = 2'd2;
    dwell_lo = 4'd2; dwell_hi = 4'd9;
    do_reset();
    ticks(10);
    chk("R8", int'(dwell_hold), 1, "hold at top");
    plateau(10, n);
    chk("R8", n, 3, "first plateau strobes");
    cur_tag = "R9";
    ticks(19);
    plateau(-10, n);
    chk("R9", n, 4, "second plateau strobes");
    cur_tag = "R10";
    ticks(19);
    dwell_lo = 4'd0; dwell_hi = 4'd0;
    plateau(10, n);
    chk("R10", n, 5, "third plateau after bound change");

    // R6 shrink range while beyond new limit
    cur_tag = "R6";
    do_reset();
    tri_range_sel = 2'd1;
    ticks(20);
    chk("R6", int'(freq_offset), 20, "before shrink");
    tri_range_sel = 2'd2;
    cyc(1);
    chk("R6", int'(freq_offset), 19, "back toward zero");
    ticks(9);
    chk("R6", int'(freq_offset), 10, "inside new range");
    cyc(1);
    chk("R6", int'(freq_offset), 9, "keeps descending");

    // random phase
    cur_tag = "R4";
    for (int blk = 0; blk < 40; blk++) begin
      tri_range_sel = 2'($urandom_range(0, 3));
      dwell_lo = 4'($urandom_range(0, 15));
      dwell_hi = 4'($urandom_range(0, 15));
      ss_mode = ($urandom_range(0, 9) == 0) ? 2'd2 : 2'($urandom_range(0, 1) * 2 + 1);
      for (int k = 0; k < 120; k++) cyc(1'($urandom_range(0, 2) != 0));
    end

    finish_run();
  end
endmodule